// File: doc/BRIEF.md
# Two-Lane Sample Demultiplexer with Synchronised Hold

The block takes one 12-bit offset-binary converter code on every encode clock edge. It delays each code by a fixed number of edges and converts it to two's complement. It then deals the codes out alternately onto two output lanes, A and B, so each lane runs at half the encode rate. Each lane has its own ready strobe. The strobe is high for the one cycle after that lane's data register loads, and the data stays put until the lane's next load.

An asynchronous hold request lets downstream capture memories start on a known sample. The request passes through a synchroniser. While the synchronised request is high, both strobes stay low, and every code that leaves the delay line in that time is thrown away. After release, the next code to emerge always goes to lane A. The delay line keeps moving during a hold, so the timing of later samples does not shift. An active-low reset empties the delay line, and no strobe appears until codes captured after reset reach its end.

Top module: `adc_lane_demux`

## Requirements
- R1: The lane value is the input code with its top bit inverted. Mid-scale 2048 gives 0x000, 4095 gives 0x7FF, 0 gives 0x800 and 2047 gives 0xFFF.
- R2: With no hold, successive emitted codes alternate lanes A, B, A, B. An a_rdy pulse always comes in the cycle just before each b_rdy pulse.
- R3: A code captured on encode edge k is loaded into its lane on edge k+LATENCY (default 40), and that lane's strobe is high after that same edge.
- R4: Each strobe is high for exactly the one cycle after its lane loads. a_rdy and b_rdy are never high together.
- R5: A lane's data changes only on an edge after which that lane's strobe is high. At all other times it holds its last value.
- R6: While the synchronised hold is high, neither strobe is high, and the codes leaving the delay line in that time never appear on either lane.
- R7: The first code emitted after a hold ends always goes to lane A.
- R8: A hold level captured on edge j first affects the lane outputs on edge j+SYNC_STAGES (default 2).
- R9: While rst_n is low, both strobes and both lane data buses are zero. After release, no strobe appears before edge first+LATENCY, where "first" is the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | CODE_W | Offset-binary converter code, one per edge |
| lag_req | input | 1 | Hold request, active high, may be asynchronous |
| a_data | output | CODE_W | Lane A two's-complement data |
| a_rdy | output | 1 | Lane A ready strobe |
| b_data | output | CODE_W | Lane B two's-complement data |
| b_rdy | output | 1 | Lane B ready strobe |

## Verification
A fixed table of codes covers both rails, mid-scale and its neighbours, and mixed bit patterns. This tells a top-bit inversion apart from a subtract or a full invert, and because the table codes are emitted on alternating lanes it also checks which lane each code reaches. A long ramp with a scrambled step checks timing only: the exact edge of the first strobe and of every later load, which catches a delay line one stage too short or too long. Hold pulses of several lengths check that no strobe appears during a hold and that lane A always comes first on resume. One of these pulses is a single cycle, which checks the synchroniser delay edge by edge. A reset in the middle of the run checks that the outputs clear and that the delay line refills before any strobe returns.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;
  typedef enum logic {LANE_A = 1'b0, LANE_B = 1'b1} lane_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[i] <= 1'b0;
      else        sh[i] <= sh[i-1];
    end
  end

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/sample_delay.sv
module sample_delay #(
  parameter int W     = 12,
  parameter int DEPTH = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         tail_vld,
  output logic [W-1:0] tail_dat
);
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     dat [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    dat[0] <= din;
    for (int i = 1; i < DEPTH; i++) dat[i] <= dat[i-1];
  end

  assign tail_vld = vld[DEPTH-1];
  assign tail_dat = dat[DEPTH-1];
endmodule

// File: rtl/lane_split.sv
module lane_split
  import adc_demux_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tail_vld,
  input  logic [W-1:0] tail_dat,
  input  logic         hold_s,
  output logic [W-1:0] a_data,
  output logic         a_rdy,
  output logic [W-1:0] b_data,
  output logic         b_rdy
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] ob_to_tc(input logic [W-1:0] c);
    return c ^ TOP_BIT;
  endfunction

  lane_e      next_lane;
  logic       emit;
  logic       load_a;
  logic       load_b;

  assign emit   = tail_vld && !hold_s;
  assign load_a = emit && (next_lane == LANE_A);
  assign load_b = emit && (next_lane == LANE_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_lane <= LANE_A;
      a_data    <= '0;
      b_data    <= '0;
      a_rdy     <= 1'b0;
      b_rdy     <= 1'b0;
    end else begin
      a_rdy <= load_a;
      b_rdy <= load_b;
      if (load_a) a_data <= ob_to_tc(tail_dat);
      if (load_b) b_data <= ob_to_tc(tail_dat);
      if (hold_s)      next_lane <= LANE_A;
      else if (load_a) next_lane <= LANE_B;
      else if (load_b) next_lane <= LANE_A;
    end
  end

  // R4
  rdy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rdy && b_rdy));
  // R4
  a_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rdy |=> !a_rdy);
  // R2
  b_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_rdy |-> $past(a_rdy));
  // R5
  a_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_data != $past(a_data)) |-> a_rdy);
  // R5
  b_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_data != $past(b_data)) |-> b_rdy);
  // R6
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> (!a_rdy && !b_rdy));
  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_vld |=> (!a_rdy && !b_rdy));
  // R7
  resume_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_s) && !hold_s && tail_vld) |=> a_rdy);
endmodule

// File: rtl/adc_lane_demux.sv
module adc_lane_demux #(
  parameter int CODE_W      = 12,
  parameter int LATENCY     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              lag_req,
  output logic [CODE_W-1:0] a_data,
  output logic              a_rdy,
  output logic [CODE_W-1:0] b_data,
  output logic              b_rdy
);
  localparam int DELAY_DEPTH = LATENCY;

  logic              hold_s;
  logic              tail_vld;
  logic [CODE_W-1:0] tail_dat;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (lag_req),
    .sync_out (hold_s)
  );

  sample_delay #(.W(CODE_W), .DEPTH(DELAY_DEPTH)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (code_in),
    .tail_vld (tail_vld),
    .tail_dat (tail_dat)
  );

  lane_split #(.W(CODE_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .tail_vld (tail_vld),
    .tail_dat (tail_dat),
    .hold_s   (hold_s),
    .a_data   (a_data),
    .a_rdy    (a_rdy),
    .b_data   (b_data),
    .b_rdy    (b_rdy)
  );
endmodule

// File: tb/sim_adc_lane_demux.sv
module sim_adc_lane_demux;
  localparam int LAT = 40;
  localparam int SYN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] code_in = '0;
  logic        lag_req = 1'b0;
  logic [11:0] a_data, b_data;
  logic        a_rdy, b_rdy;

  always #5 clk = ~clk;

  adc_lane_demux u0 (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .lag_req(lag_req),
    .a_data(a_data), .a_rdy(a_rdy), .b_data(b_data), .b_rdy(b_rdy)
  );

  // {input code, expected two's-complement value} for R1
  localparam logic [23:0] VEC [16] = '{
    {12'd2048, 12'h000}, {12'd4095, 12'h7FF}, {12'd0,    12'h800},
    {12'd2047, 12'hFFF}, {12'd1,    12'h801}, {12'd4094, 12'h7FE},
    {12'd2049, 12'h001}, {12'd1024, 12'hC00}, {12'd3072, 12'h400},
    {12'd100,  12'h864}, {12'd3000, 12'h3B8}, {12'd555,  12'hA2B},
    {12'd2730, 12'h2AA}, {12'd1365, 12'hD55}, {12'd4000, 12'h7A0},
    {12'd17,   12'h811}
  };

  int   total = 0, fails = 0;
  bit   done = 0;
  int   edge_n = 0, first_edge = 1, table_last = 0, ramp_k = 0;
  logic [11:0] exp_hist [4096];
  bit   hold_hist [4096];
  bit   m_lane_b, prev_hs, after_hold;
  logic [11:0] ea, eb;
  bit   era, erb;

  function automatic logic [11:0] tcb(input int c);
    return 12'((c + 4096 - 2048) % 4096);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, edge_n);
    end
  endtask

  task automatic model_reset();
    m_lane_b = 0; prev_hs = 0; after_hold = 0;
    ea = '0; eb = '0; era = 0; erb = 0;
  endtask

  task automatic step(input int code, input logic [11:0] expv, input bit hold);
    bit hs, valid, la, lb;
    int src;
    string rtag, dtag;
    code_in = 12'(code);
    lag_req = hold;
    @(posedge clk);
    edge_n++;
    exp_hist[edge_n]  = expv;
    hold_hist[edge_n] = hold;
    hs    = (edge_n - SYN >= first_edge) ? hold_hist[edge_n - SYN] : 1'b0;
    src   = edge_n - LAT;
    valid = (src >= first_edge);
    la = 0; lb = 0;
    if (hs != prev_hs)  rtag = "R8";
    else if (hs)        rtag = "R6";
    else if (!valid)    rtag = "R9";
    else                rtag = "R3";
    dtag = "R2";
    if (valid && !hs) begin
      if (after_hold) dtag = "R7";
      else if (src <= table_last) dtag = "R1";
      after_hold = 0;
      if (!m_lane_b) begin la = 1; ea = exp_hist[src]; end
      else           begin lb = 1; eb = exp_hist[src]; end
      m_lane_b = !m_lane_b;
    end
    if (hs) begin m_lane_b = 0; after_hold = 1; end
    era = la; erb = lb; prev_hs = hs;
    @(negedge clk);
    chk(a_rdy === era, rtag, "a_rdy", int'(a_rdy), int'(era));
    chk(b_rdy === erb, rtag, "b_rdy", int'(b_rdy), int'(erb));
    chk(!(a_rdy && b_rdy), "R4", "both strobes", int'({a_rdy, b_rdy}), 0);
    chk(a_data === ea, la ? dtag : "R5", "a_data", int'(a_data), int'(ea));
    chk(b_data === eb, lb ? dtag : "R5", "b_data", int'(b_data), int'(eb));
  endtask

  task automatic ramp(input int n, input bit hold);
    for (int i = 0; i < n; i++) begin
      int c;
      c = (ramp_k * 389 + 7) % 4096;
      ramp_k++;
      step(c, tcb(c), hold);
    end
  endtask

  task automatic check_reset_state();
    #1;
    chk(a_rdy === 1'b0 && b_rdy === 1'b0, "R9", "reset strobes",
        int'({a_rdy, b_rdy}), 0);
    chk(a_data === 12'h000, "R9", "reset a_data", int'(a_data), 0);
    chk(b_data === 12'h000, "R9", "reset b_data", int'(b_data), 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    first_edge = edge_n + 1;
    for (int i = 0; i < 16; i++) step(int'(VEC[i][23:12]), VEC[i][11:0], 1'b0);
    table_last = edge_n;
    ramp(50, 0);
    ramp(5, 1);
    ramp(20, 0);
    ramp(1, 1);
    ramp(7, 0);
    ramp(3, 1);
    ramp(60, 0);
    rst_n = 1'b0;
    check_reset_state();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    first_edge = edge_n + 1;
    model_reset();
    ramp(50, 0);
    ramp(2, 1);
    ramp(10, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule